// File: doc/BRIEF.md
# Euler-Stepped Chaotic Oscillator

This block generates the three coordinates of a continuous three-dimensional chaotic flow, sampled with forward Euler integration. Each coordinate is a 32-bit signed fixed-point value with 8 integer bits and 24 fractional bits. A downstream mixing stage reads the coordinates as raw chaotic material.

A 2-bit selector chooses one of four attractor families. Each family has its own fixed constants and its own starting point. The selector is captured during reset, and the starting point of the chosen family is loaded at the same time. After reset, every cycle in which the step input is high advances the trajectory by exactly one Euler step. The step size is a power of two, so the increment is formed by an arithmetic right shift and needs no multiplier.

A one-cycle valid strobe marks each new triple. Between steps the outputs hold their values.

Top module: `chaos_osc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block captures `mode_i`, loads the starting point of that family into (x, y, z) and drives `valid_o` low. The starting points are: family 0 at (0, 5, 25); family 1 at 0.1 on all three axes; families 2 and 3 at 1 on all three axes.
- R2: A rising edge with `step_i` high and reset released gives a new triple on the outputs, with `valid_o` high, in the following cycle. A rising edge with `step_i` low gives `valid_o` low in the following cycle.
- R3: A rising edge with `step_i` low leaves `x_o`, `y_o` and `z_o` unchanged.
- R4: A change of `mode_i` while reset is released has no effect on the trajectory until the next reset.
- R5: Family 0 (`mode_i`=0) uses the derivatives dx = a(y−x), dy = b·x − y − x·z and dz = x·y − c·z, with a=10, b=28 and c=8/3.
- R6: Family 1 (`mode_i`=1) uses the derivatives dx = −(y+z), dy = x + a·y and dz = b + z·(x−c), with a=0.2, b=0.2 and c=5.7.
- R7: Family 2 (`mode_i`=2) uses the derivatives dx = a(y−x), dy = (c−a)·x − x·z + c·y and dz = x·y − b·z, with a=35, b=3 and c=28.
- R8: Family 3 (`mode_i`=3) uses the derivatives dx = a(y−x), dy = c·y − x·z and dz = x·y − b·z, with a=36, b=3 and c=20.
- R9: The number format is signed Q8.24. Constants are rounded to the nearest Q8.24 code. Every product is rounded as floor((p + 2^23) / 2^24). All three derivatives are computed from the old state. Each new coordinate is old + floor(d / 2^8), saturated to the range [−2^31, 2^31−1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; captures the family and loads its starting point |
| mode_i | input | 2 | Attractor family selector, used only during reset |
| step_i | input | 1 | Advances the trajectory by one Euler step when high |
| x_o | output | 32 | x coordinate, signed Q8.24 |
| y_o | output | 32 | y coordinate, signed Q8.24 |
| z_o | output | 32 | z coordinate, signed Q8.24 |
| valid_o | output | 1 | High for one cycle after each step |

## Verification
The assertions check on every cycle the rules that do not depend on any arithmetic:
- the valid strobe tracks the step input one cycle later;
- the coordinates stay frozen between steps;
- the captured family stays fixed while reset is released;
- reset loads the correct starting point.

Only the bench's scenarios can show that each family's equations, constants, rounding and shift are bit-exact. The bench does this by running long stepping sequences against an independent integer model. It also covers the cases where `mode_i` is toggled during operation, or reset is applied in the middle of a run.

// File: rtl/chaos_osc_pkg.sv
// Package: shared widths, types and per-family constants of the chaotic
// oscillator. Assumes Q8.24 state; all constants are computed, not tabulated.
package chaos_osc_pkg;

    localparam int STATE_W = 32;                       // coordinate width
    localparam int FRAC_W  = 24;                       // fractional bits
    localparam int OPND_W  = STATE_W + 2;              // room for differences
    localparam int DERIV_W = 2 * OPND_W - FRAC_W;      // rescaled product width
    localparam int NUM_MUL = 6;                        // shared multipliers

    typedef logic signed [STATE_W-1:0] fx_t;
    typedef logic signed [OPND_W-1:0]  opnd_t;
    typedef logic signed [DERIV_W-1:0] deriv_t;

    typedef enum logic [1:0] {
        FAM_LORENZ  = 2'd0,
        FAM_ROSSLER = 2'd1,
        FAM_CHEN    = 2'd2,
        FAM_LU      = 2'd3
    } family_e;

    typedef struct packed {
        fx_t ka;
        fx_t kb;
        fx_t kc;
    } coef_t;

    typedef struct packed {
        fx_t x;
        fx_t y;
        fx_t z;
    } triple_t;

    // Integer to Q8.24.
    function automatic fx_t fx_int(input int n);
        return fx_t'(longint'(n) <<< FRAC_W);
    endfunction

    // Ratio num/den to Q8.24, rounded to nearest.
    function automatic fx_t fx_ratio(input int num, input int den);
        return fx_t'((((longint'(num) <<< (FRAC_W + 1)) / den) + 1) >>> 1);
    endfunction

    // Constants of each family.
    function automatic coef_t coef_of(input family_e fam);
        coef_t k;
        case (fam)
            FAM_LORENZ:  k = '{fx_int(10), fx_int(28), fx_ratio(8, 3)};
            FAM_ROSSLER: k = '{fx_ratio(2, 10), fx_ratio(2, 10), fx_ratio(57, 10)};
            FAM_CHEN:    k = '{fx_int(35), fx_int(3), fx_int(28)};
            default:     k = '{fx_int(36), fx_int(3), fx_int(20)};
        endcase
        return k;
    endfunction

    // Starting point of each family.
    function automatic triple_t seed_of(input family_e fam);
        triple_t s;
        case (fam)
            FAM_LORENZ:  s = '{fx_int(0), fx_int(5), fx_int(25)};
            FAM_ROSSLER: s = '{fx_ratio(1, 10), fx_ratio(1, 10), fx_ratio(1, 10)};
            default:     s = '{fx_int(1), fx_int(1), fx_int(1)};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/chaos_osc_fxmul.sv
// Fixed-point multiplier: full signed product of two operands, rounded
// half-up back to the fractional scale. Assumes OUT_W = 2*IN_W - FRAC.
module chaos_osc_fxmul #(
    parameter int IN_W  = 34,
    parameter int FRAC  = 24,
    parameter int OUT_W = 2 * IN_W - FRAC
) (
    input  logic signed [IN_W-1:0]  a_i,
    input  logic signed [IN_W-1:0]  b_i,
    output logic signed [OUT_W-1:0] p_o
);
    localparam int PROD_W = 2 * IN_W;
    localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(64'sd1 <<< (FRAC - 1));

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rounded;

    // Full product, then add half an output LSB.
    always_comb begin
        prod    = a_i * b_i;
        rounded = prod + HALF_LSB;
    end

    // Drop the fractional excess (floor).
    assign p_o = OUT_W'(rounded >>> FRAC);
endmodule

// File: rtl/chaos_osc_deriv.sv
// Derivative unit: steers the old state and the family constants onto a
// bank of shared multipliers, then sums the products into dx, dy, dz.
// Assumes the family is stable while the state is being stepped.
module chaos_osc_deriv
    import chaos_osc_pkg::*;
(
    input  family_e fam_i,
    input  fx_t     x_i,
    input  fx_t     y_i,
    input  fx_t     z_i,
    output deriv_t  dx_o,
    output deriv_t  dy_o,
    output deriv_t  dz_o
);
    opnd_t  op_a [NUM_MUL];
    opnd_t  op_b [NUM_MUL];
    deriv_t prd  [NUM_MUL];
    coef_t  k;
    opnd_t  xs, ys, zs, kas, kbs, kcs;
    deriv_t xd, yd, zd, kbd;

    assign k = coef_of(fam_i);

    // Sign extension of state and constants to operand and derivative widths.
    always_comb begin
        xs  = opnd_t'(x_i);
        ys  = opnd_t'(y_i);
        zs  = opnd_t'(z_i);
        kas = opnd_t'(k.ka);
        kbs = opnd_t'(k.kb);
        kcs = opnd_t'(k.kc);
        xd  = deriv_t'(x_i);
        yd  = deriv_t'(y_i);
        zd  = deriv_t'(z_i);
        kbd = deriv_t'(k.kb);
    end

    // Operand steering per family; unused multipliers see zero.
    always_comb begin
        for (int i = 0; i < NUM_MUL; i++) begin
            op_a[i] = '0;
            op_b[i] = '0;
        end
        case (fam_i)
            FAM_ROSSLER: begin
                op_a[1] = zs;   op_b[1] = xs - kcs;
                op_a[2] = kas;  op_b[2] = ys;
            end
            default: begin
                op_a[0] = kas;  op_b[0] = ys - xs;
                op_a[1] = xs;   op_b[1] = zs;
                op_a[2] = xs;   op_b[2] = ys;
                if (fam_i == FAM_LORENZ) begin
                    op_a[3] = kcs;        op_b[3] = zs;
                    op_a[4] = kbs;        op_b[4] = xs;
                end else if (fam_i == FAM_CHEN) begin
                    op_a[3] = kbs;        op_b[3] = zs;
                    op_a[4] = kcs - kas;  op_b[4] = xs;
                    op_a[5] = kcs;        op_b[5] = ys;
                end else begin
                    op_a[3] = kbs;        op_b[3] = zs;
                    op_a[4] = kcs;        op_b[4] = ys;
                end
            end
        endcase
    end

    // Bank of identical rounding multipliers.
    for (genvar g = 0; g < NUM_MUL; g++) begin : g_mul
        chaos_osc_fxmul #(
            .IN_W  (OPND_W),
            .FRAC  (FRAC_W),
            .OUT_W (DERIV_W)
        ) u_mul (
            .a_i (op_a[g]),
            .b_i (op_b[g]),
            .p_o (prd[g])
        );
    end

    // Sum the products into the three derivatives.
    always_comb begin
        case (fam_i)
            FAM_ROSSLER: begin
                dx_o = -(yd + zd);
                dy_o = xd + prd[2];
                dz_o = kbd + prd[1];
            end
            FAM_LORENZ: begin
                dx_o = prd[0];
                dy_o = prd[4] - yd - prd[1];
                dz_o = prd[2] - prd[3];
            end
            default: begin
                dx_o = prd[0];
                dy_o = prd[4] - prd[1] + prd[5];
                dz_o = prd[2] - prd[3];
            end
        endcase
    end
endmodule

// File: rtl/chaos_osc_euler.sv
// Euler update: adds the derivative, scaled by 2^-STEP_SHIFT through an
// arithmetic shift, to each coordinate and saturates to the state range.
module chaos_osc_euler
    import chaos_osc_pkg::*;
#(
    parameter int STEP_SHIFT = 8
) (
    input  triple_t cur_i,
    input  deriv_t  dx_i,
    input  deriv_t  dy_i,
    input  deriv_t  dz_i,
    output triple_t nxt_o
);
    localparam int SUM_W = DERIV_W + 1;
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'(fx_t'({1'b0, {(STATE_W-1){1'b1}}}));
    localparam logic signed [SUM_W-1:0] SAT_LO = SUM_W'(fx_t'({1'b1, {(STATE_W-1){1'b0}}}));

    fx_t    cur [3];
    deriv_t der [3];
    fx_t    nxt [3];

    assign cur[0] = cur_i.x;
    assign cur[1] = cur_i.y;
    assign cur[2] = cur_i.z;
    assign der[0] = dx_i;
    assign der[1] = dy_i;
    assign der[2] = dz_i;

    for (genvar g = 0; g < 3; g++) begin : g_axis
        logic signed [SUM_W-1:0] sum;
        // Scaled increment added to the old coordinate, then clamped.
        always_comb begin
            sum = SUM_W'(cur[g]) + SUM_W'(der[g] >>> STEP_SHIFT);
            if (sum > SAT_HI)      nxt[g] = fx_t'(SAT_HI);
            else if (sum < SAT_LO) nxt[g] = fx_t'(SAT_LO);
            else                   nxt[g] = fx_t'(sum);
        end
    end

    assign nxt_o = '{nxt[0], nxt[1], nxt[2]};
endmodule

// File: rtl/chaos_osc.sv
// Chaotic oscillator top: holds the family captured in reset and the
// current (x, y, z) triple. It advances one Euler step per step_i cycle
// and flags each new triple with a one-cycle valid strobe.
// Assumes a synchronous active-low reset.
module chaos_osc
    import chaos_osc_pkg::*;
#(
    parameter int STEP_SHIFT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic               step_i,
    output logic signed [31:0] x_o,
    output logic signed [31:0] y_o,
    output logic signed [31:0] z_o,
    output logic               valid_o
);
    family_e fam_q;
    triple_t st_q;
    triple_t st_nxt;
    deriv_t  dx, dy, dz;
    logic    valid_q;

    chaos_osc_deriv u_deriv (
        .fam_i (fam_q),
        .x_i   (st_q.x),
        .y_i   (st_q.y),
        .z_i   (st_q.z),
        .dx_o  (dx),
        .dy_o  (dy),
        .dz_o  (dz)
    );

    chaos_osc_euler #(
        .STEP_SHIFT (STEP_SHIFT)
    ) u_euler (
        .cur_i (st_q),
        .dx_i  (dx),
        .dy_i  (dy),
        .dz_i  (dz),
        .nxt_o (st_nxt)
    );

    // Capture the family and its seed in reset; otherwise step on demand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fam_q   <= family_e'(mode_i);
            st_q    <= seed_of(family_e'(mode_i));
            valid_q <= 1'b0;
        end else begin
            valid_q <= step_i;
            if (step_i) st_q <= st_nxt;
        end
    end

    assign x_o     = st_q.x;
    assign y_o     = st_q.y;
    assign z_o     = st_q.z;
    assign valid_o = valid_q;

    // R2
    step_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> valid_o);

    // R2
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> !valid_o);

    // R3
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));

    // R4
    family_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(fam_q));

    // R1
    reset_seed_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && {x_o, y_o, z_o} == seed_of(fam_q)));
endmodule

// File: tb/chaos_osc_bench.sv
// Bench: a behavioural integer model of each family's Euler step, compared
// with the outputs on every clock.
module chaos_osc_bench;
    localparam int  WATCHDOG = 150000;
    localparam real SCALE    = 16777216.0;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         mode_i = 2'd0;
    logic               step_i = 1'b0;
    logic signed [31:0] x_o, y_o, z_o;
    logic               valid_o;

    int     n_vec  = 0;
    int     n_bad  = 0;
    int     cycles = 0;
    longint mx, my, mz;
    int     mfam = 0;
    logic   mvalid = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    chaos_osc u_chaos_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .step_i  (step_i),
        .x_o     (x_o),
        .y_o     (y_o),
        .z_o     (z_o),
        .valid_o (valid_o)
    );

    function automatic longint q(input real r);
        return longint'($floor(r * SCALE + 0.5));
    endfunction

    function automatic longint fm(input longint a, input longint b);
        return (a * b + (64'sd1 <<< 23)) >>> 24;
    endfunction

    function automatic longint clamp(input longint v);
        if (v > 64'sd2147483647)  return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    task automatic model_seed(input int fam);
        mfam = fam;
        case (fam)
            0:       begin mx = q(0.0); my = q(5.0); mz = q(25.0); end
            1:       begin mx = q(0.1); my = q(0.1); mz = q(0.1);  end
            default: begin mx = q(1.0); my = q(1.0); mz = q(1.0);  end
        endcase
    endtask

    task automatic model_step();
        longint dx, dy, dz;
        case (mfam)
            0: begin
                dx = fm(q(10.0), my - mx);
                dy = fm(q(28.0), mx) - my - fm(mx, mz);
                dz = fm(mx, my) - fm(q(8.0 / 3.0), mz);
            end
            1: begin
                dx = -(my + mz);
                dy = mx + fm(q(0.2), my);
                dz = q(0.2) + fm(mz, mx - q(5.7));
            end
            2: begin
                dx = fm(q(35.0), my - mx);
                dy = fm(q(28.0) - q(35.0), mx) - fm(mx, mz) + fm(q(28.0), my);
                dz = fm(mx, my) - fm(q(3.0), mz);
            end
            default: begin
                dx = fm(q(36.0), my - mx);
                dy = fm(q(20.0), my) - fm(mx, mz);
                dz = fm(mx, my) - fm(q(3.0), mz);
            end
        endcase
        mx = clamp(mx + (dx >>> 8));
        my = clamp(my + (dy >>> 8));
        mz = clamp(mz + (dz >>> 8));
    endtask

    // One clock: drive inputs, advance the model at the edge, compare at negedge.
    task automatic tick(input logic rn, input logic [1:0] md, input logic st, input string tag);
        rst_n  = rn;
        mode_i = md;
        step_i = st;
        @(posedge clk);
        if (!rn) begin
            model_seed(int'(md));
            mvalid = 1'b0;
        end else begin
            mvalid = st;
            if (st) model_step();
        end
        @(negedge clk);
        n_vec++;
        if (longint'(x_o) != mx || longint'(y_o) != my || longint'(z_o) != mz || valid_o !== mvalid) begin
            n_bad++;
            $display("FAIL %s: got x=%0d y=%0d z=%0d v=%0b, expected x=%0d y=%0d z=%0d v=%0b",
                     tag, x_o, y_o, z_o, valid_o, mx, my, mz, mvalid);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic run_family(input logic [1:0] fam, input string tag);
        tick(1'b0, fam, 1'b0, "R1");
        tick(1'b0, fam, 1'b1, "R1");
        for (int i = 0; i < 1500; i++) tick(1'b1, fam, 1'b1, {tag, "/R9"});
        for (int i = 0; i < 20; i++)   tick(1'b1, fam, 1'b0, "R3");
        for (int i = 0; i < 400; i++)  tick(1'b1, fam, next_bit(), "R2");
        for (int i = 0; i < 300; i++)  tick(1'b1, fam ^ 2'(i + 1), (i % 3) != 0, "R4");
        tick(1'b0, fam ^ 2'd1, 1'b1, "R1");
        for (int i = 0; i < 100; i++)  tick(1'b1, fam, 1'b1, "R4");
    endtask

    initial begin
        @(negedge clk);
        run_family(2'd0, "R5");
        run_family(2'd1, "R6");
        run_family(2'd2, "R7");
        run_family(2'd3, "R8");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule